// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This controller loads a configuration image into a programmable device through a one-bit slave-serial port. It drives the program strobe, the configuration clock and the serial data line. It also watches the device's init and done indications. Configuration bytes come in over a valid/ready stream, and the number of bytes to send is given when the load starts.

A load runs through a fixed sequence of steps. The controller asserts program and waits for init to become active, then releases program and waits for init to clear. After that it checks for a device-reported CRC error before each byte and shifts each byte out with the most significant bit first. When the last byte has gone out, it keeps clocking with data held high until done rises. The result is reported as a one-cycle pulse carrying a two-bit code. A readback request is not supported on a serial port, so it is rejected at once.

States: `S_IDLE`, `S_PROG_ON`, `S_PROG_OFF`, `S_BYTE_CHK`, `S_SHIFT`, `S_FLUSH` and `S_FINISH`. The transitions are:

- `S_IDLE` goes to `S_PROG_ON` on a start in load mode, or to `S_FINISH` on a start in readback mode.
- `S_PROG_ON` goes to `S_PROG_OFF` when init becomes active, or to `S_FINISH` on timeout.
- `S_PROG_OFF` goes to `S_BYTE_CHK` when init clears, to `S_FLUSH` instead if the byte count is zero, or to `S_FINISH` on timeout.
- `S_BYTE_CHK` goes to `S_SHIFT` when a byte is accepted, to `S_FLUSH` when no bytes remain, or to `S_FINISH` on a CRC error.
- `S_SHIFT` returns to `S_BYTE_CHK` once all eight bits have been clocked out.
- `S_FLUSH` goes to `S_FINISH` when done rises or on timeout.
- `S_FINISH` returns to `S_IDLE`.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset, `cfg_prog`, `busy`, `in_ready` and `res_valid` are all low.
- R2: A start with `readback` low raises `cfg_prog` in the next cycle. `cfg_prog` stays high until the cycle after `cfg_init` is seen high; it can also end through a timeout.
- R3: If `cfg_init` does not become high within `TIMEOUT_CYC` cycles of program being asserted, the load ends with code 1 (timeout).
- R4: If `cfg_init` does not clear within `TIMEOUT_CYC` cycles of program being released, the load ends with code 1 and no byte is accepted.
- R5: Each byte is sent most significant bit first, one bit per rising edge of `cfg_clk`. `cfg_din` changes only while `cfg_clk` is low, one system clock after the falling edge.
- R6: A new byte is accepted only after all eight bits of the previous byte have had their rising edge. Exactly `byte_total` bytes are accepted in a load that completes.
- R7: Before each byte, if `cfg_init` is high while `cfg_done` is low, the load ends with code 2 (CRC error) and no further byte is accepted.
- R8: After the last byte, `cfg_din` is high on every further rising edge of `cfg_clk`. Clocking stops when `cfg_done` rises, and the result is code 0 (success).
- R9: If `cfg_done` does not rise within `TIMEOUT_CYC` cycles of the flush phase starting, the load ends with code 1.
- R10: A start with `readback` high gives `res_valid` with code 3 (unsupported) in the next cycle and never asserts `cfg_prog`.
- R11: `busy` is high from the cycle after a start until the result. `res_valid` is a single-cycle pulse.
- R12: With `byte_total` equal to zero, no byte is accepted and the controller goes straight from releasing program to the flush phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle command to begin, taken only when idle |
| readback | input | 1 | Mode qualifier for start; 1 requests readback |
| byte_total | input | CNT_W | Number of bytes to load, captured at start |
| in_valid | input | 1 | Input stream byte valid |
| in_data | input | 8 | Input stream byte |
| in_ready | output | 1 | Controller accepts the byte this cycle |
| cfg_prog | output | 1 | Program strobe to the device, active high |
| cfg_clk | output | 1 | Configuration clock to the device |
| cfg_din | output | 1 | Serial configuration data |
| cfg_init | input | 1 | Device init indication, active high |
| cfg_done | input | 1 | Device done indication |
| busy | output | 1 | A command is in progress |
| res_valid | output | 1 | One-cycle result strobe |
| res_code | output | 2 | 0 success, 1 timeout, 2 CRC error, 3 unsupported |

## Verification
The hardest case to reach from the ports is the CRC abort. It needs the device to signal an error exactly at a byte boundary, after the last rising edge of one byte and before the next byte is accepted. The bench device model counts rising edges of `cfg_clk` and raises init the moment a chosen byte completes. The controller must then stop with that byte count accepted. The other timeout phases are reached by holding init or done at the wrong level from the device model. The stream valid is dropped at random so that byte accept times vary.

// File: rtl/cfg_loader_pkg.sv
`timescale 1ns/1ps
package cfg_loader_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PROG_ON,
        S_PROG_OFF,
        S_BYTE_CHK,
        S_SHIFT,
        S_FLUSH,
        S_FINISH
    } ld_state_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_TIMEOUT = 2'd1,
        RES_CRC     = 2'd2,
        RES_UNSUPP  = 2'd3
    } ld_res_e;

endpackage

// File: rtl/cfg_wait_timer.sv
`timescale 1ns/1ps
// Cycle counter for wait phases. It restarts at zero on request and flags
// expiry on the LIMIT-th cycle after the restart.
module cfg_wait_timer #(
    parameter int LIMIT = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expired = (cnt_q == LAST);
endmodule

// File: rtl/cfg_bit_shifter.sv
`timescale 1ns/1ps
// Serialises one word MSB first. Each bit has HALF_CYC low cycles, then
// HALF_CYC high cycles. Data changes one cycle after the clock falls, so
// HALF_CYC must be at least 2. The clock is left high after the last bit.
module cfg_bit_shifter #(
    parameter int HALF_CYC = 2,
    parameter int W        = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         halt,
    input  logic [W-1:0] word_in,
    output logic         busy,
    output logic         sclk,
    output logic         sdo
);
    localparam int PH_W = $clog2(2 * HALF_CYC);
    localparam int BI_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [PH_W-1:0] RISE_PH = PH_W'(HALF_CYC - 1);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(2 * HALF_CYC - 1);
    localparam logic [BI_W-1:0] LAST_BI = BI_W'(W - 1);

    logic            active_q;
    logic [PH_W-1:0] ph_q;
    logic [BI_W-1:0] bi_q;
    logic [W-1:0]    sreg_q;
    logic            sclk_q;
    logic            sdo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            ph_q     <= '0;
            bi_q     <= '0;
            sreg_q   <= '0;
            sclk_q   <= 1'b0;
            sdo_q    <= 1'b0;
        end else if (halt) begin
            active_q <= 1'b0;
        end else if (load) begin
            active_q <= 1'b1;
            ph_q     <= '0;
            bi_q     <= '0;
            sreg_q   <= word_in;
            sclk_q   <= 1'b0;
        end else if (active_q) begin
            if (ph_q == '0) begin
                sdo_q <= sreg_q[W-1];
            end
            if (ph_q == RISE_PH) begin
                sclk_q <= 1'b1;
            end
            if (ph_q == LAST_PH) begin
                ph_q <= '0;
                if (bi_q == LAST_BI) begin
                    active_q <= 1'b0;
                end else begin
                    bi_q   <= bi_q + BI_W'(1);
                    sreg_q <= sreg_q << 1;
                    sclk_q <= 1'b0;
                end
            end else begin
                ph_q <= ph_q + PH_W'(1);
            end
        end
    end

    assign busy = active_q;
    assign sclk = sclk_q;
    assign sdo  = sdo_q;
endmodule

// File: rtl/serial_cfg_loader.sv
`timescale 1ns/1ps
module serial_cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int HALF_CYC    = 2,
    parameter int TIMEOUT_CYC = 500000,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             readback,
    input  logic [CNT_W-1:0] byte_total,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             cfg_prog,
    output logic             cfg_clk,
    output logic             cfg_din,
    input  logic             cfg_init,
    input  logic             cfg_done,
    output logic             busy,
    output logic             res_valid,
    output logic [1:0]       res_code
);
    ld_state_e        state_q, state_d;
    ld_res_e          res_q, res_d;
    logic [CNT_W-1:0] rem_q;
    logic             tmo;
    logic             restart;
    logic             crc_hit;
    logic             take;
    logic             sh_load, sh_halt, sh_busy;
    logic [BYTE_BITS-1:0] sh_word;
    logic             in_flush;

    assign crc_hit = cfg_init && !cfg_done;

    // state register and result code
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            res_q   <= RES_OK;
        end else begin
            state_q <= state_d;
            res_q   <= res_d;
        end
    end

    // remaining byte count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (state_q == S_IDLE && start) begin
            rem_q <= byte_total;
        end else if (take) begin
            rem_q <= rem_q - CNT_W'(1);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        res_d   = res_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    if (readback) begin
                        res_d   = RES_UNSUPP;
                        state_d = S_FINISH;
                    end else begin
                        state_d = S_PROG_ON;
                    end
                end
            end
            S_PROG_ON: begin
                if (cfg_init) begin
                    state_d = S_PROG_OFF;
                end else if (tmo) begin
                    res_d   = RES_TIMEOUT;
                    state_d = S_FINISH;
                end
            end
            S_PROG_OFF: begin
                if (!cfg_init) begin
                    state_d = (rem_q == '0) ? S_FLUSH : S_BYTE_CHK;
                end else if (tmo) begin
                    res_d   = RES_TIMEOUT;
                    state_d = S_FINISH;
                end
            end
            S_BYTE_CHK: begin
                if (rem_q == '0) begin
                    state_d = S_FLUSH;
                end else if (crc_hit) begin
                    res_d   = RES_CRC;
                    state_d = S_FINISH;
                end else if (in_valid) begin
                    state_d = S_SHIFT;
                end
            end
            S_SHIFT: begin
                if (!sh_busy) begin
                    state_d = S_BYTE_CHK;
                end
            end
            S_FLUSH: begin
                if (cfg_done) begin
                    res_d   = RES_OK;
                    state_d = S_FINISH;
                end else if (tmo) begin
                    res_d   = RES_TIMEOUT;
                    state_d = S_FINISH;
                end
            end
            S_FINISH: begin
                state_d = S_IDLE;
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // outputs and shifter control
    always_comb begin
        in_flush  = (state_q == S_FLUSH);
        cfg_prog  = (state_q == S_PROG_ON);
        busy      = (state_q != S_IDLE);
        res_valid = (state_q == S_FINISH);
        res_code  = res_q;
        in_ready  = (state_q == S_BYTE_CHK) && (rem_q != '0) && !crc_hit;
        take      = in_ready && in_valid;
        sh_halt   = in_flush && (cfg_done || tmo);
        sh_load   = take || (in_flush && !sh_busy && !cfg_done && !tmo);
        sh_word   = in_flush ? '1 : in_data;
        restart   = (state_d != state_q);
    end

    cfg_wait_timer #(
        .LIMIT (TIMEOUT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .expired (tmo)
    );

    cfg_bit_shifter #(
        .HALF_CYC (HALF_CYC),
        .W        (BYTE_BITS)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .halt    (sh_halt),
        .word_in (sh_word),
        .busy    (sh_busy),
        .sclk    (cfg_clk),
        .sdo     (cfg_din)
    );
endmodule

// File: rtl/cfg_loader_chk.sv
`timescale 1ns/1ps
module cfg_loader_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       readback,
    input logic       busy,
    input logic       cfg_prog,
    input logic       cfg_init,
    input logic       cfg_done,
    input logic       cfg_clk,
    input logic       cfg_din,
    input logic       in_ready,
    input logic       res_valid,
    input logic [1:0] res_code,
    input logic       sh_busy,
    input logic       in_flush
);
    // R2: program is released early only when the result is reported at the same time
    p_prog_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cfg_prog) && !res_valid) |-> $past(cfg_init));

    // R5: data is steady across each rising edge of the configuration clock
    p_din_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_clk) |-> $stable(cfg_din));

    // R6: a byte is offered to the stream only while the serialiser is idle
    p_ready_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !sh_busy);

    // R7: no byte is accepted while the device reports a CRC error
    p_crc_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !(cfg_init && !cfg_done));

    // R8: data is high on every rising edge during the flush phase
    p_flush_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flush && $rose(cfg_clk)) |-> cfg_din);

    // R10: a readback request is rejected in the next cycle
    p_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && readback && !busy) |=> (res_valid && res_code == 2'd3 && !cfg_prog));

    // R11: the result strobe lasts one cycle
    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
endmodule

bind serial_cfg_loader cfg_loader_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .readback  (readback),
    .busy      (busy),
    .cfg_prog  (cfg_prog),
    .cfg_init  (cfg_init),
    .cfg_done  (cfg_done),
    .cfg_clk   (cfg_clk),
    .cfg_din   (cfg_din),
    .in_ready  (in_ready),
    .res_valid (res_valid),
    .res_code  (res_code),
    .sh_busy   (sh_busy),
    .in_flush  (in_flush)
);

// File: tb/sim_serial_cfg_loader.sv
`timescale 1ns/1ps
module sim_serial_cfg_loader;
    localparam int HALF = 2;
    localparam int TMO  = 300;
    localparam int CW   = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          readback = 1'b0;
    logic [CW-1:0] byte_total = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          in_ready;
    logic          cfg_prog, cfg_clk, cfg_din;
    logic          cfg_init, cfg_done;
    logic          busy, res_valid;
    logic [1:0]    res_code;

    always #10 clk = ~clk;

    serial_cfg_loader #(.HALF_CYC(HALF), .TIMEOUT_CYC(TMO), .CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .readback(readback),
        .byte_total(byte_total), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .cfg_prog(cfg_prog), .cfg_clk(cfg_clk),
        .cfg_din(cfg_din), .cfg_init(cfg_init), .cfg_done(cfg_done),
        .busy(busy), .res_valid(res_valid), .res_code(res_code)
    );

    int total = 0;
    int bad   = 0;

    // case configuration (driven by the main sequence only)
    logic       case_rst = 1'b0;
    int         n_cur = 0, done_after = 0, crc_at = 0, init_mode = 0;
    logic       feed_en = 1'b0;
    logic [7:0] data_q [0:31];

    // device model and monitors
    logic       init_model = 1'b0;
    logic       crc_flag = 1'b0, done_flag = 1'b0;
    int         pdly = 0, rdly = 0, din_viol = 0, early_rel = 0;
    logic       prog_seen = 1'b0, rel_done = 1'b0;
    logic       last_prog = 1'b0, last_clk = 1'b0, last_din = 1'b0;
    int         feed_idx = 0;
    int         bits_seen = 0, flush_cnt = 0, flush_low = 0;
    logic [7:0] shreg = 8'h00;
    logic [7:0] rx_q [0:31];

    assign cfg_init = init_model | crc_flag;
    assign cfg_done = done_flag;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // device init behaviour and port monitors
    always @(negedge clk) begin
        if (case_rst) begin
            init_model = 1'b0; prog_seen = 1'b0; rel_done = 1'b0;
            pdly = 0; rdly = 0; din_viol = 0; early_rel = 0;
        end else begin
            if (last_prog && !cfg_prog && !cfg_init && !res_valid) early_rel++;
            if (cfg_clk && last_clk && (cfg_din != last_din)) din_viol++;
            if (cfg_prog) begin
                prog_seen = 1'b1;
                pdly++;
                if (pdly > 3 && init_mode != 1) init_model = 1'b1;
            end else if (prog_seen && init_model && !rel_done && init_mode == 0) begin
                rdly++;
                if (rdly > 4) begin
                    init_model = 1'b0;
                    rel_done = 1'b1;
                end
            end
        end
        last_prog = cfg_prog;
        last_clk  = cfg_clk;
        last_din  = cfg_din;
    end

    // stream source
    always @(negedge clk) begin
        if (feed_en && !case_rst && feed_idx < n_cur) begin
            in_valid = (($urandom % 4) != 0);
            in_data  = data_q[feed_idx];
        end else begin
            in_valid = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (case_rst) begin
            feed_idx = 0;
        end else if (in_valid && in_ready) begin
            // R6: a byte is taken only when all bits of the previous byte have been clocked
            check(bits_seen == 8 * feed_idx, "R6", bits_seen, 8 * feed_idx);
            feed_idx++;
        end
    end

    // device serial capture
    always @(posedge cfg_clk or posedge case_rst) begin
        if (case_rst) begin
            bits_seen = 0; flush_cnt = 0; flush_low = 0; shreg = 8'h00;
            crc_flag <= 1'b0;
            done_flag <= 1'b0;
        end else begin
            bits_seen++;
            if (bits_seen <= 8 * n_cur) begin
                shreg = {shreg[6:0], cfg_din};
                if (bits_seen % 8 == 0) begin
                    rx_q[bits_seen / 8 - 1] = shreg;
                    if (crc_at != 0 && bits_seen / 8 == crc_at) crc_flag <= 1'b1;
                end
            end else begin
                if (!cfg_din) flush_low++;
                flush_cnt++;
                if (done_after != 0 && flush_cnt == done_after) done_flag <= 1'b1;
            end
        end
    end

    function automatic int exp_code(int n, int mode, int crc, int dn, bit rdbk);
        if (rdbk) return 3;
        if (mode != 0) return 1;
        if (crc > 0 && crc < n) return 2;
        if (dn == 0) return 1;
        return 0;
    endfunction

    function automatic int exp_taken(int n, int mode, int crc, bit rdbk);
        if (rdbk || mode != 0) return 0;
        if (crc > 0 && crc < n) return crc;
        return n;
    endfunction

    function automatic logic [7:0] pattern_byte(int pat, int i);
        case (pat)
            1: return 8'h80 >> (i % 8);
            2: return (i % 2 == 0) ? 8'hFF : 8'h00;
            3: return 8'h01 << (i % 8);
            default: return 8'($urandom);
        endcase
    endfunction

    task automatic run_case(input int n, input int mode, input int crc, input int dn,
                            input bit rdbk, input int pat, input string tag);
        int cyc;
        int ec, et, mism, code;
        @(negedge clk);
        case_rst = 1'b1;
        n_cur = n; done_after = dn; crc_at = crc; init_mode = mode;
        for (int i = 0; i < 32; i++) data_q[i] = pattern_byte(pat, i);
        feed_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        case_rst = 1'b0;
        @(negedge clk);
        start = 1'b1; readback = rdbk; byte_total = CW'(n);
        @(negedge clk);
        start = 1'b0; readback = 1'b0;
        check(busy == 1'b1, "R11", busy, 1);
        cyc = 1;
        while (!res_valid && cyc < 6000) begin
            @(negedge clk);
            cyc++;
        end
        check(res_valid == 1'b1, tag, res_valid, 1);
        code = res_code;
        ec = exp_code(n, mode, crc, dn, rdbk);
        et = exp_taken(n, mode, crc, rdbk);
        check(code == ec, tag, code, ec);
        @(negedge clk);
        check(res_valid == 1'b0, "R11", res_valid, 0);
        check(feed_idx == et, "R6", feed_idx, et);
        mism = 0;
        for (int i = 0; i < et; i++) if (rx_q[i] !== data_q[i]) mism++;
        check(mism == 0, "R5", mism, 0);
        check(din_viol == 0, "R5", din_viol, 0);
        check(early_rel == 0, "R2", early_rel, 0);
        if (ec == 0) begin
            check(flush_cnt == dn, "R8", flush_cnt, dn);
            check(flush_low == 0, "R8", flush_low, 0);
        end
        if (ec == 2) check(bits_seen == 8 * crc, "R7", bits_seen, 8 * crc);
        if (ec == 1) check(cyc >= TMO, tag, cyc, TMO);
        if (rdbk) begin
            check(prog_seen == 1'b0, "R10", prog_seen, 0);
            check(cyc == 1, "R10", cyc, 1);
        end else begin
            check(prog_seen == 1'b1, "R2", prog_seen, 1);
        end
        feed_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cfg_prog == 1'b0, "R1", cfg_prog, 0);
        check(busy == 1'b0, "R1", busy, 0);
        check(in_ready == 1'b0, "R1", in_ready, 0);
        check(res_valid == 1'b0, "R1", res_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_case(5, 0, 0, 3, 1'b0, 1, "R8");   // directed bit patterns
        run_case(4, 0, 0, 2, 1'b0, 2, "R8");
        run_case(3, 0, 0, 1, 1'b0, 3, "R8");
        run_case(2, 0, 0, 4, 1'b1, 0, "R10");  // readback rejected
        run_case(3, 1, 0, 4, 1'b0, 0, "R3");   // init never active
        run_case(3, 2, 0, 4, 1'b0, 0, "R4");   // init never clears
        run_case(6, 0, 2, 4, 1'b0, 0, "R7");   // CRC after byte 2
        run_case(4, 0, 1, 4, 1'b0, 0, "R7");   // CRC after first byte
        run_case(3, 0, 0, 0, 1'b0, 0, "R9");   // done never rises
        run_case(0, 0, 0, 4, 1'b0, 0, "R12");  // empty image
        for (int k = 0; k < 6; k++) begin
            run_case(1 + int'($urandom % 16), 0, 0, 1 + int'($urandom % 10), 1'b0, 0, "R8");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule